// File: doc/BRIEF.md
# Serial Boot Loader Protocol Sequencer

This block runs the byte-level conversation between a host and a chip that boots over a UART. Once the UART reports that the baud rate is locked, the sequencer sends a lock byte, waits for a synchronisation byte from the host, and answers it. It then takes a 16-bit program length, upper byte first, echoing both length bytes. Each of the following program bytes is echoed to the host and written to on-chip RAM at consecutive addresses.

After the last byte, the sequencer consults a blank flag from the flash controller. If the flash already holds data, it requests a full erase. The result goes back to the host as a one-byte code: 0xAA on success, 0xFF on failure. A failure parks the sequencer in a halted state. A success raises a sticky boot-complete flag, which tells the core to branch into the loaded code.

Received bytes arrive as a valid/data stream with a framing-error flag. The UART cannot be stalled, so this stream has no ready. Echoes and replies leave through a one-entry valid/ready transmit stream. A byte stays presented, unchanged, until the host side takes it with ready. While that byte is pending, the sequencer refuses new received bytes and records each refusal as an overrun.

Top module: `boot_loader_seq`

## Requirements
- R1: After reset, tx_valid, ram_we, erase_req, overrun, boot_done and halted are all low.
- R2: Before lock_i is seen, received bytes are ignored and nothing is sent. The first cycle with lock_i high queues the byte 0x00 for transmission.
- R3: While waiting for synchronisation, only a clean 0x55 is answered, and the answer is 0xAA. Any other byte is ignored without reply.
- R4: The length N is taken as two bytes, upper byte then lower byte. Each length byte is echoed unchanged.
- R5: Program byte i (counting from 0) is echoed unchanged and written to RAM at address BASE+i. The write is a single-cycle ram_we pulse, raised in the same cycle that the echo is first presented.
- R6: When N is zero, no RAM write occurs and the sequencer moves straight to the flash step.
- R7: When flash_blank is high at the flash step, erase_req is never raised, and 0xAA is sent.
- R8: When flash_blank is low, erase_req is raised and held until erase_done or erase_fail. Done leads to 0xAA. Fail (which wins if both are high) leads to 0xFF, after which halted stays high, boot_done stays low, and received bytes are ignored.
- R9: boot_done rises only after the 0xAA result byte has been accepted by the transmit stream. It then stays high until reset.
- R10: A byte flagged with rx_ferr while the sequencer is waiting for synchronisation, length or program bytes is not echoed or written. It returns the sequencer to waiting for 0x55.
- R11: A clean byte that arrives in those receiving states while tx_valid is high is dropped without echo or write. It sets the sticky overrun output.
- R12: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Baud rate lock reached; starts the handshake |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Received byte had a framing error |
| tx_valid | output | 1 | A byte is offered for transmission |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| tx_data | output | 8 | Byte offered for transmission |
| ram_we | output | 1 | RAM write strobe, one cycle per byte |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| flash_blank | input | 1 | Flash holds no programmed data |
| erase_req | output | 1 | Full flash erase request, held until answered |
| erase_done | input | 1 | Erase finished successfully |
| erase_fail | input | 1 | Erase could not be completed |
| overrun | output | 1 | Sticky: a byte arrived while an echo was pending |
| boot_done | output | 1 | Sticky: loading and erase succeeded, branch to RAM |
| halted | output | 1 | Sticky: erase failed, sequencer stopped |

## Verification
Two events can meet in one cycle: a new received byte, and an echo that is still waiting for tx_ready. The bench provokes this by forcing tx_ready low so that the lock byte stays pending, then delivers 0x55 at once. It judges the outcome at the ports: overrun must be set, no 0xAA may ever leave, and the stalled byte must stay unchanged. A framing error that lands while the length is being read is also checked. It must discard the byte and send the sequencer back to synchronisation, and the bench confirms this because the next non-0x55 byte then draws no echo.

// File: rtl/boot_loader_seq_pkg.sv
package boot_loader_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SYNC,
    ST_LEN_HI,
    ST_LEN_LO,
    ST_LOAD,
    ST_CHECK,
    ST_ERASE,
    ST_REP_OK,
    ST_REP_BAD,
    ST_FIN,
    ST_DONE,
    ST_HALT
  } seq_state_e;

  localparam logic [7:0] LOCK_BYTE = 8'h00;
  localparam logic [7:0] SYNC_REQ  = 8'h55;
  localparam logic [7:0] SYNC_ACK  = 8'hAA;
  localparam logic [7:0] RES_OK    = 8'hAA;
  localparam logic [7:0] RES_BAD   = 8'hFF;
  localparam int         LEN_W     = 16;
endpackage

// File: rtl/boot_loader_seq_txslot.sv
module boot_loader_seq_txslot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  logic [7:0] data_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  input  logic       tx_ready_i
);
  // Single holding register; the sequencer only pushes when it is empty.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= 8'h00;
    end else if (push_i) begin
      tx_valid_o <= 1'b1;
      tx_data_o  <= data_i;
    end else if (tx_ready_i) begin
      tx_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/boot_loader_seq_cnt.sv
module boot_loader_seq_cnt #(
  parameter int                LEN_W  = 16,
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [LEN_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      addr_o   <= BASE;
    end else if (load_i) begin
      remain_q <= len_i;
      addr_o   <= BASE;
    end else if (step_i) begin
      remain_q <= remain_q - 1'b1;
      addr_o   <= addr_o + 1'b1;
    end
  end

  assign last_o = (remain_q == {{(LEN_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/boot_loader_seq.sv
module boot_loader_seq
  import boot_loader_seq_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'h0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_ferr,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic              flash_blank,
  output logic              erase_req,
  input  logic              erase_done,
  input  logic              erase_fail,
  output logic              overrun,
  output logic              boot_done,
  output logic              halted
);
  seq_state_e        state_q, state_d;
  logic [7:0]        len_hi_q;
  logic              push;
  logic [7:0]        push_data;
  logic              cnt_load, cnt_step, wr_now;
  logic [ADDR_W-1:0] cnt_addr;
  logic              cnt_last;
  logic              rx_live, take, ferr_hit, ovr_hit;

  assign rx_live  = (state_q == ST_SYNC) || (state_q == ST_LEN_HI) ||
                    (state_q == ST_LEN_LO) || (state_q == ST_LOAD);
  assign take     = rx_live && rx_valid && !rx_ferr && !tx_valid;
  assign ferr_hit = rx_live && rx_valid && rx_ferr;
  assign ovr_hit  = rx_live && rx_valid && !rx_ferr && tx_valid;

  always_comb begin
    state_d   = state_q;
    push      = 1'b0;
    push_data = 8'h00;
    cnt_load  = 1'b0;
    cnt_step  = 1'b0;
    wr_now    = 1'b0;
    case (state_q)
      ST_IDLE: if (lock_i) begin
        push      = 1'b1;
        push_data = LOCK_BYTE;
        state_d   = ST_SYNC;
      end
      ST_SYNC: if (take && rx_data == SYNC_REQ) begin
        push      = 1'b1;
        push_data = SYNC_ACK;
        state_d   = ST_LEN_HI;
      end
      ST_LEN_HI: if (take) begin
        push      = 1'b1;
        push_data = rx_data;
        state_d   = ST_LEN_LO;
      end
      ST_LEN_LO: if (take) begin
        push      = 1'b1;
        push_data = rx_data;
        cnt_load  = 1'b1;
        state_d   = ({len_hi_q, rx_data} == 16'd0) ? ST_CHECK : ST_LOAD;
      end
      ST_LOAD: if (take) begin
        push      = 1'b1;
        push_data = rx_data;
        wr_now    = 1'b1;
        cnt_step  = 1'b1;
        if (cnt_last) state_d = ST_CHECK;
      end
      ST_CHECK:  state_d = flash_blank ? ST_REP_OK : ST_ERASE;
      ST_ERASE: begin
        if (erase_fail)      state_d = ST_REP_BAD;
        else if (erase_done) state_d = ST_REP_OK;
      end
      ST_REP_OK: if (!tx_valid) begin
        push      = 1'b1;
        push_data = RES_OK;
        state_d   = ST_FIN;
      end
      ST_REP_BAD: if (!tx_valid) begin
        push      = 1'b1;
        push_data = RES_BAD;
        state_d   = ST_HALT;
      end
      ST_FIN:  if (!tx_valid) state_d = ST_DONE;
      default: state_d = state_q;
    endcase
    if (ferr_hit) state_d = ST_SYNC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      len_hi_q  <= 8'h00;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= 8'h00;
      overrun   <= 1'b0;
    end else begin
      state_q <= state_d;
      ram_we  <= wr_now;
      if (take && state_q == ST_LEN_HI) len_hi_q <= rx_data;
      if (wr_now) begin
        ram_addr  <= cnt_addr;
        ram_wdata <= rx_data;
      end
      if (ovr_hit) overrun <= 1'b1;
    end
  end

  assign erase_req = (state_q == ST_ERASE);
  assign boot_done = (state_q == ST_DONE);
  assign halted    = (state_q == ST_HALT);

  boot_loader_seq_txslot u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .data_i     (push_data),
    .tx_valid_o (tx_valid),
    .tx_data_o  (tx_data),
    .tx_ready_i (tx_ready)
  );

  boot_loader_seq_cnt #(
    .LEN_W  (LEN_W),
    .ADDR_W (ADDR_W),
    .BASE   (BASE)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cnt_load),
    .len_i  ({len_hi_q, rx_data}),
    .step_i (cnt_step),
    .addr_o (cnt_addr),
    .last_o (cnt_last)
  );
endmodule

// File: rtl/boot_loader_seq_chk.sv
module boot_loader_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [7:0]        ram_wdata,
  input logic              erase_req,
  input logic              erase_done,
  input logic              erase_fail,
  input logic              overrun,
  input logic              boot_done,
  input logic              halted
);
  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done && !halted);

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !erase_req && !boot_done);

  // R8
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && !erase_done && !erase_fail |=> erase_req);

  // R5
  wr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> tx_valid && tx_data == ram_wdata);

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  logic unused_addr;
  assign unused_addr = ^ram_addr;
endmodule

bind boot_loader_seq boot_loader_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .ram_wdata  (ram_wdata),
  .erase_req  (erase_req),
  .erase_done (erase_done),
  .erase_fail (erase_fail),
  .overrun    (overrun),
  .boot_done  (boot_done),
  .halted     (halted)
);

// File: tb/sim_boot_loader_seq.sv
module sim_boot_loader_seq;
  localparam logic [15:0] BASE = 16'h0400;

  logic        clk = 1'b0;
  logic        rst_n, lock_i, rx_valid, rx_ferr, tx_ready;
  logic [7:0]  rx_data;
  logic        flash_blank, erase_done, erase_fail;
  logic        tx_valid, ram_we, erase_req, overrun, boot_done, halted;
  logic [7:0]  tx_data, ram_wdata;
  logic [15:0] ram_addr;

  always #4 clk = ~clk;

  boot_loader_seq #(.ADDR_W(16), .BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .flash_blank(flash_blank), .erase_req(erase_req),
    .erase_done(erase_done), .erase_fail(erase_fail),
    .overrun(overrun), .boot_done(boot_done), .halted(halted)
  );

  int n_chk = 0, n_fail = 0;
  int ready_mode = 0;  // 0 random, 1 hold low, 2 always high
  logic [7:0]  act_tx [0:511];
  logic [7:0]  exp_tx [0:511];
  logic [15:0] act_wa [0:511];
  logic [7:0]  act_wd [0:511];
  logic [7:0]  exp_wd [0:511];
  int act_n = 0, exp_n = 0, wr_n = 0, exp_wr_n = 0, req_seen = 0;

  // Monitor: drive ready just after falling edge, then log what the next edge takes.
  initial begin
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      tx_ready = (ready_mode == 2) ? 1'b1 :
                 (ready_mode == 1) ? 1'b0 : 1'($urandom % 2);
      #1;
      if (rst_n === 1'b1) begin
        if (tx_valid && tx_ready && act_n < 512) begin
          act_tx[act_n] = tx_data; act_n++;
        end
        if (ram_we && wr_n < 512) begin
          act_wa[wr_n] = ram_addr; act_wd[wr_n] = ram_wdata; wr_n++;
        end
        if (erase_req) req_seen++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_tx(input logic [7:0] b);
    exp_tx[exp_n] = b; exp_n++;
  endtask

  task automatic cmp_tx(input string req);
    chk(act_n == exp_n, req, "tx byte count", act_n, exp_n);
    for (int i = 0; i < exp_n && i < act_n; i++)
      chk(act_tx[i] == exp_tx[i], req, $sformatf("tx byte %0d", i),
          act_tx[i], exp_tx[i]);
  endtask

  task automatic cmp_ram(input string req);
    chk(wr_n == exp_wr_n, req, "ram write count", wr_n, exp_wr_n);
    for (int i = 0; i < exp_wr_n && i < wr_n; i++) begin
      chk(act_wa[i] == BASE + 16'(i), req, $sformatf("ram addr %0d", i),
          act_wa[i], BASE + 16'(i));
      chk(act_wd[i] == exp_wd[i], req, $sformatf("ram data %0d", i),
          act_wd[i], exp_wd[i]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lock_i = 1'b0; rx_valid = 1'b0; rx_ferr = 1'b0;
    rx_data = 8'h00; flash_blank = 1'b0; erase_done = 1'b0; erase_fail = 1'b0;
    ready_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    act_n = 0; exp_n = 0; wr_n = 0; exp_wr_n = 0; req_seen = 0;
  endtask

  task automatic wait_tx_idle();
    @(negedge clk);
    while (tx_valid) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic ferr, input bit wait_idle);
    if (wait_idle) wait_tx_idle();
    else @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_ferr = ferr;
    @(negedge clk);
    rx_valid = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic pulse_lock();
    @(negedge clk); lock_i = 1'b1;
    @(negedge clk); lock_i = 1'b0;
  endtask

  task automatic wait_sig(input int which);
    int k = 0;
    while (k < 400 && !((which == 0 && erase_req) || (which == 1 && boot_done) ||
                        (which == 2 && halted))) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic load_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      send_rx(b, 1'b0, 1'b1);
      expect_tx(b);
      exp_wd[exp_wr_n] = b; exp_wr_n++;
    end
  endtask

  task automatic prologue(input int n);
    pulse_lock(); expect_tx(8'h00);
    send_rx(8'h55, 1'b0, 1'b1); expect_tx(8'hAA);
    send_rx(8'(n >> 8), 1'b0, 1'b1); expect_tx(8'(n >> 8));
    send_rx(8'(n), 1'b0, 1'b1); expect_tx(8'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual=%0h expected=%0h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_0B07));

    // ---- Run 1: full load, erase succeeds ----
    do_reset();
    @(negedge clk);
    chk(!tx_valid && !ram_we && !erase_req && !overrun && !boot_done && !halted,
        "R1", "reset outputs", {tx_valid, ram_we, erase_req, overrun, boot_done, halted}, 0);
    send_rx(8'h55, 1'b0, 1'b0);              // R2: before lock, ignored
    repeat (4) @(negedge clk);
    chk(act_n == 0, "R2", "no tx before lock", act_n, 0);
    pulse_lock(); expect_tx(8'h00);
    wait_tx_idle();
    cmp_tx("R2");
    send_rx(8'h12, 1'b0, 1'b1);              // R3: wrong sync ignored
    repeat (4) @(negedge clk);
    chk(act_n == 1, "R3", "no reply to non-sync byte", act_n, 1);
    send_rx(8'h55, 1'b0, 1'b1); expect_tx(8'hAA);
    n = 1 + int'($urandom % 24);
    send_rx(8'(n >> 8), 1'b0, 1'b1); expect_tx(8'(n >> 8));   // R4
    send_rx(8'(n), 1'b0, 1'b1); expect_tx(8'(n));
    wait_tx_idle();
    cmp_tx("R4");
    load_bytes(n);
    flash_blank = 1'b0;
    wait_sig(0);
    chk(erase_req, "R8", "erase requested on non-blank flash", erase_req, 1);
    repeat (int'($urandom % 8)) @(negedge clk);
    chk(erase_req, "R8", "erase request held", erase_req, 1);
    erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
    expect_tx(8'hAA);
    wait_sig(1);
    repeat (5) @(negedge clk);
    chk(boot_done && !halted, "R9", "boot_done sticky", boot_done, 1);
    cmp_tx("R5");
    cmp_ram("R5");

    // ---- Run 2: zero length, blank flash ----
    do_reset();
    prologue(0);
    flash_blank = 1'b1;
    wait_sig(1);
    expect_tx(8'hAA);
    repeat (3) @(negedge clk);
    cmp_tx("R7");
    chk(wr_n == 0, "R6", "no ram writes for N=0", wr_n, 0);
    chk(req_seen == 0, "R7", "no erase request on blank flash", req_seen, 0);
    chk(boot_done, "R9", "boot_done after blank", boot_done, 1);

    // ---- Run 3: length with nonzero upper byte ----
    do_reset();
    n = 16'h0102;
    prologue(n);
    load_bytes(n);
    flash_blank = 1'b0;
    wait_sig(0);
    erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
    expect_tx(8'hAA);
    wait_sig(1);
    repeat (3) @(negedge clk);
    cmp_tx("R4");
    cmp_ram("R5");

    // ---- Run 4: overrun, framing error, erase failure ----
    do_reset();
    ready_mode = 1;
    pulse_lock(); expect_tx(8'h00);
    send_rx(8'h55, 1'b0, 1'b0);              // arrives while 0x00 pending
    @(negedge clk);
    chk(overrun, "R11", "overrun set", overrun, 1);
    repeat (5) @(negedge clk);
    chk(tx_valid && tx_data == 8'h00, "R12", "stalled byte held", tx_data, 0);
    ready_mode = 0;
    wait_tx_idle();
    repeat (3) @(negedge clk);
    chk(act_n == 1, "R11", "dropped byte not answered", act_n, 1);
    send_rx(8'h55, 1'b0, 1'b1); expect_tx(8'hAA);
    send_rx(8'h00, 1'b0, 1'b1); expect_tx(8'h00);
    send_rx(8'h02, 1'b1, 1'b1);              // R10: framing error in length
    send_rx(8'h02, 1'b0, 1'b1);              // back in sync wait: ignored
    repeat (4) @(negedge clk);
    chk(act_n == 3, "R10", "framing error restarts sync", act_n, 3);
    prologue_skip_lock: begin
      send_rx(8'h55, 1'b0, 1'b1); expect_tx(8'hAA);
      send_rx(8'h00, 1'b0, 1'b1); expect_tx(8'h00);
      send_rx(8'h02, 1'b0, 1'b1); expect_tx(8'h02);
    end
    load_bytes(2);
    flash_blank = 1'b0;
    wait_sig(0);
    erase_fail = 1'b1; erase_done = 1'b1; @(negedge clk);
    erase_fail = 1'b0; erase_done = 1'b0;
    expect_tx(8'hFF);
    wait_sig(2);
    send_rx(8'h55, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    chk(halted && !boot_done, "R8", "halted after failed erase", {halted, boot_done}, 2);
    cmp_tx("R8");
    cmp_ram("R10");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule